// File: doc/BRIEF.md
# 24-Pin GPIO Expander Register Bank

This block holds the register file and pin logic of a 24-pin general-purpose I/O expander. It sits behind a byte-wide register bus of the kind a serial target front end would drive. The pins form a general bank of 16 (indices 0 to 15) and an alternate bank of 8 (indices 16 to 23). A control register enables each bank on its own. Each pin has a direction bit, a drive-type bit, a pull-up enable and an output latch. Software changes the latch only through separate write-one-to-set and write-one-to-clear registers, so it never needs a read-modify-write to move one pin.

Each per-pin function takes three consecutive byte registers. Pin n is bit n%8 of register base+n/8. Input pads pass through a two-flop synchronizer before they show in the pin-state registers.

The bus has an address pointer that increments after every access. A host can therefore read several consecutive registers in one burst, for example both firmware version bytes. A software reset bit returns all configuration to its defaults. The block then reports busy for a parameterised number of clock cycles.

Top module: `gpio_xpander_regs`

## Requirements
- R1: After hardware reset, every read/write register is 0, both banks are disabled, pin_oe, pin_out and pin_pu are all 0, and busy is 0.
- R2: Address 0x00 reads the bitwise complement of the 8-bit bus address {BASE_ADDR7[6:1], addr_sel, 0}. With the default base this is 0x7B for addr_sel=0 and 0x79 for addr_sel=1.
- R3: Addresses 0x01 and 0x02 read FW_HI and FW_LO. Every access moves the pointer to the accessed address plus one. An access with bus_ld=0 uses the pointer, so a load-read of 0x01 followed by a plain read returns FW_HI then FW_LO.
- R4: Direction registers 0x60..0x62 hold pin n at 0x60+n/8, bit n%8. A 1 makes the pin an output, which drives pin_oe while its bank is enabled. A 0 makes it an input.
- R5: A write to 0x6C..0x6E sets the latch bits whose data bit is 1. A write to 0x70..0x72 clears the latch bits whose data bit is 1. Data bits of 0 leave their latches unchanged. Both register sets read back the latch.
- R6: A type bit of 1 (registers 0x64..0x66) selects open-drain drive: the pin is enabled only while its latch is 0. A type bit of 0 selects push-pull. A pull bit of 1 (registers 0x68..0x6A) drives pin_pu for that pin while its bank is enabled.
- R7: Control register 0x40 bit 0 enables pins 0..15 and bit 3 enables pins 16..23. While a bank is disabled, its pins have pin_oe, pin_out and pin_pu at 0, and their pin-state bits read 0.
- R8: Pin-state registers 0x10..0x12 show the pad inputs through two synchronizer flops. They show the pad value, not the latch.
- R9: Writing 0x40 with bit 7 set returns all configuration to its defaults and holds busy high for BOOT_CYCLES cycles.
- R10: While busy is 1, writes are ignored and reads return 0x00.
- R11: Reads from unmapped addresses return 0x00. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Bus address select strap |
| bus_ld | input | 1 | Use bus_addr for this access instead of the pointer |
| bus_addr | input | 8 | Register address when bus_ld is 1 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | bus_rdata holds the result of the previous cycle's read |
| busy | output | 1 | Boot interval after software reset |
| pin_in | input | 24 | Pad input values |
| pin_out | output | 24 | Pad output values |
| pin_oe | output | 24 | Pad output enables |
| pin_pu | output | 24 | Pad pull-up enables |

## Verification
Register writes take effect on the clock edge that samples them. Because the pin outputs are combinational from the registers, pin_out, pin_oe and pin_pu are checked at the next falling edge. Read data and bus_rvalid are registered, so they are due one edge after the strobe. A scoreboard queues each expected byte when the read is issued and compares it on the falling edge where bus_rvalid is high. A pad change reaches bus_rdata after three edges (two synchronizer flops plus the read register), so the bench waits three cycles before reading pin state. Busy rises at the edge of the reset write and stays high for exactly BOOT_CYCLES edges. The bench checks it right after that write, probes writes and reads inside the window, and samples again well past its end.

// File: rtl/gxp_pkg.sv
package gxp_pkg;
    localparam int NUM_PINS   = 24;
    localparam int GEN_PINS   = 16;
    localparam int BYTE_W     = 8;
    localparam int NUM_GROUPS = NUM_PINS / BYTE_W;

    localparam logic [7:0] A_CHIPID = 8'h00;
    localparam logic [7:0] A_FW_HI  = 8'h01;
    localparam logic [7:0] A_FW_LO  = 8'h02;
    localparam logic [7:0] A_STATE  = 8'h10;
    localparam logic [7:0] A_SYS    = 8'h40;
    localparam logic [7:0] A_DIR    = 8'h60;
    localparam logic [7:0] A_TYPE   = 8'h64;
    localparam logic [7:0] A_PULL   = 8'h68;
    localparam logic [7:0] A_SET    = 8'h6C;
    localparam logic [7:0] A_CLR    = 8'h70;

    localparam int SYS_GEN_BIT = 0;
    localparam int SYS_ALT_BIT = 3;
    localparam int SYS_RST_BIT = 7;

    typedef struct packed {
        logic                gen_en;
        logic                alt_en;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] otype;
        logic [NUM_PINS-1:0] pull;
        logic [NUM_PINS-1:0] latch;
        logic [7:0]          ptr;
        logic [7:0]          rdata;
        logic                rvalid;
    } xp_state_t;

    function automatic logic [BYTE_W-1:0] grp_byte(input logic [NUM_PINS-1:0] v,
                                                   input logic [1:0] g);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_GROUPS; k++)
            if (int'(g) == k) r = v[k*BYTE_W +: BYTE_W];
        return r;
    endfunction

    function automatic logic [NUM_PINS-1:0] grp_place(input logic [1:0] g,
                                                      input logic [BYTE_W-1:0] b);
        logic [NUM_PINS-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_GROUPS; k++)
            if (int'(g) == k) r[k*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction
endpackage

// File: rtl/gxp_sync.sv
module gxp_sync #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/gxp_boot_timer.sv
module gxp_boot_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/gxp_pin_ctrl.sv
module gxp_pin_ctrl
    import gxp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_en,
    input  logic                alt_en,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] otype,
    input  logic [NUM_PINS-1:0] pull,
    input  logic [NUM_PINS-1:0] latch,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic en;
        if (i < GEN_PINS) begin : g_gen
            assign en = gen_en;
        end else begin : g_alt
            assign en = alt_en;
        end
        assign pin_out[i] = en & latch[i];
        assign pin_oe[i]  = en & dir[i] & (~otype[i] | ~latch[i]);
        assign pin_pu[i]  = en & pull[i];
    end

    p_alt_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |-> (pin_oe[NUM_PINS-1:GEN_PINS] == '0 && pin_pu[NUM_PINS-1:GEN_PINS] == '0));
    p_od_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & otype & latch) == '0);
endmodule

// File: rtl/gpio_xpander_regs.sv
module gpio_xpander_regs
    import gxp_pkg::*;
#(
    parameter int         BOOT_CYCLES = 500000,
    parameter logic [6:0] BASE_ADDR7  = 7'h42,
    parameter logic [7:0] FW_HI       = 8'h01,
    parameter logic [7:0] FW_LO       = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_sel,
    input  logic                bus_ld,
    input  logic [7:0]          bus_addr,
    input  logic                bus_we,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_re,
    output logic [7:0]          bus_rdata,
    output logic                bus_rvalid,
    output logic                busy,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu
);
    xp_state_t st_d, st_q;

    logic [NUM_PINS-1:0] pad_sync;
    logic [NUM_PINS-1:0] bank_en;
    logic [7:0]          eff;
    logic [1:0]          grp;
    logic                grp_ok;
    logic                wr_ok;
    logic                swrst;
    logic [7:0]          rd_val;
    logic [7:0]          chip_id;

    gxp_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_sync)
    );

    gxp_boot_timer #(.CYCLES(BOOT_CYCLES)) u_boot (
        .clk(clk), .rst_n(rst_n), .start(swrst), .busy(busy)
    );

    gxp_pin_ctrl u_pins (
        .clk(clk), .rst_n(rst_n),
        .gen_en(st_q.gen_en), .alt_en(st_q.alt_en),
        .dir(st_q.dir), .otype(st_q.otype), .pull(st_q.pull), .latch(st_q.latch),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    assign chip_id = ~{BASE_ADDR7[6:1], addr_sel, 1'b0};

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++)
            bank_en[i] = (i < GEN_PINS) ? st_q.gen_en : st_q.alt_en;
    end

    always_comb begin
        eff    = bus_ld ? bus_addr : st_q.ptr;
        grp    = eff[1:0];
        grp_ok = int'(grp) < NUM_GROUPS;
        wr_ok  = bus_we && !busy;
        swrst  = wr_ok && (eff == A_SYS) && bus_wdata[SYS_RST_BIT];

        rd_val = 8'h00;
        case (eff)
            A_CHIPID: rd_val = chip_id;
            A_FW_HI:  rd_val = FW_HI;
            A_FW_LO:  rd_val = FW_LO;
            A_SYS: begin
                rd_val[SYS_GEN_BIT] = st_q.gen_en;
                rd_val[SYS_ALT_BIT] = st_q.alt_en;
            end
            default: begin
                if (grp_ok) begin
                    case (eff & 8'hFC)
                        A_STATE: rd_val = grp_byte(pad_sync & bank_en, grp);
                        A_DIR:   rd_val = grp_byte(st_q.dir, grp);
                        A_TYPE:  rd_val = grp_byte(st_q.otype, grp);
                        A_PULL:  rd_val = grp_byte(st_q.pull, grp);
                        A_SET,
                        A_CLR:   rd_val = grp_byte(st_q.latch, grp);
                        default: rd_val = 8'h00;
                    endcase
                end
            end
        endcase

        st_d        = st_q;
        st_d.rvalid = bus_re;
        if (bus_we || bus_re)
            st_d.ptr = eff + 8'd1;
        if (bus_re)
            st_d.rdata = busy ? 8'h00 : rd_val;

        if (wr_ok) begin
            if (eff == A_SYS) begin
                st_d.gen_en = bus_wdata[SYS_GEN_BIT];
                st_d.alt_en = bus_wdata[SYS_ALT_BIT];
            end else if (grp_ok) begin
                case (eff & 8'hFC)
                    A_DIR:  st_d.dir   = (st_q.dir   & ~grp_place(grp, 8'hFF)) | grp_place(grp, bus_wdata);
                    A_TYPE: st_d.otype = (st_q.otype & ~grp_place(grp, 8'hFF)) | grp_place(grp, bus_wdata);
                    A_PULL: st_d.pull  = (st_q.pull  & ~grp_place(grp, 8'hFF)) | grp_place(grp, bus_wdata);
                    A_SET:  st_d.latch = st_q.latch |  grp_place(grp, bus_wdata);
                    A_CLR:  st_d.latch = st_q.latch & ~grp_place(grp, bus_wdata);
                    default: ;
                endcase
            end
        end

        if (swrst) begin
            st_d.gen_en = 1'b0;
            st_d.alt_en = 1'b0;
            st_d.dir    = '0;
            st_d.otype  = '0;
            st_d.pull   = '0;
            st_d.latch  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;

    p_busy_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_re) |=> (bus_rdata == 8'h00 && bus_rvalid));
    p_busy_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(st_q.dir) && $stable(st_q.latch) && $stable(st_q.gen_en)));
    p_swrst_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (busy && pin_oe == '0 && pin_pu == '0 && pin_out == '0));
    p_set_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && eff == A_SET) |=> (st_q.latch[7:0] == ($past(st_q.latch[7:0]) | $past(bus_wdata))));
    p_clr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && eff == A_CLR) |=> (st_q.latch[7:0] == ($past(st_q.latch[7:0]) & ~$past(bus_wdata))));
    p_burst_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_ld && !bus_we) |=> (st_q.ptr == $past(st_q.ptr) + 8'd1));
endmodule

// File: tb/gpio_xpander_regs_tb_top.sv
module gpio_xpander_regs_tb_top;
    localparam int         BOOT = 20;
    localparam logic [7:0] FWH  = 8'h02;
    localparam logic [7:0] FWL  = 8'h15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic        bus_ld = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic        busy;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    gpio_xpander_regs #(.BOOT_CYCLES(BOOT), .FW_HI(FWH), .FW_LO(FWL)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .bus_ld(bus_ld), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: compares read data as it appears
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected read data", 32'(bus_rdata), 32'hFFFF_FFFF);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, 32'(bus_rdata), 32'(e));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_ld = 1'b1; bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_ld = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic ld, input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_ld = ld; bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_ld = 1'b0; bus_re = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe after reset", 32'(pin_oe), 0);
        chk("R1 out after reset", 32'(pin_out), 0);
        chk("R1 busy after reset", 32'(busy), 0);
        rd(1, 8'h60, 8'h00, "R1 dir reset");
        rd(1, 8'h40, 8'h00, "R1 sysctrl reset");
        // R2 chip id
        rd(1, 8'h00, 8'h7B, "R2 chip id sel0");
        addr_sel = 1'b1;
        rd(1, 8'h00, 8'h79, "R2 chip id sel1");
        // R3 burst read
        rd(1, 8'h01, FWH, "R3 fw hi");
        rd(0, 8'h00, FWL, "R3 fw lo auto-increment");
        // R4 / R5 direction and set/clear
        wr(8'h40, 8'h01);
        wr(8'h60, 8'h05);
        wr(8'h6C, 8'h04);
        chk("R4 oe pins 0,2", 32'(pin_oe), 32'h000005);
        chk("R5 set pin2", 32'(pin_out), 32'h000004);
        wr(8'h70, 8'h04);
        wr(8'h6C, 8'h01);
        chk("R5 clear then set", 32'(pin_out), 32'h000001);
        rd(1, 8'h70, 8'h01, "R5 clear reg reads latch");
        // R7 alternate bank
        wr(8'h62, 8'h80);
        wr(8'h6E, 8'h80);
        chk("R7 alt disabled oe", 32'(pin_oe[23]), 0);
        wr(8'h40, 8'h09);
        chk("R7 alt enabled oe", 32'(pin_oe), 32'h800005);
        chk("R7 alt enabled out", 32'(pin_out), 32'h800001);
        // R6 open drain and pull
        wr(8'h64, 8'h01);
        chk("R6 od high releases", 32'(pin_oe[0]), 0);
        wr(8'h70, 8'h01);
        chk("R6 od low drives", 32'(pin_oe[0]), 1);
        chk("R6 od low value", 32'(pin_out[0]), 0);
        wr(8'h69, 8'h02);
        chk("R6 pull pin9", 32'(pin_pu), 32'h000200);
        // R8 pin state through synchronizer, pad not latch
        pin_in = 24'hA53C81;
        repeat (3) @(negedge clk);
        rd(1, 8'h10, 8'h81, "R8 state byte0 pad value");
        rd(1, 8'h11, 8'h3C, "R8 state byte1");
        rd(1, 8'h12, 8'hA5, "R8 state byte2");
        wr(8'h40, 8'h01);
        rd(1, 8'h12, 8'h00, "R7 alt off state reads 0");
        chk("R7 alt off oe", 32'(pin_oe[23]), 0);
        wr(8'h40, 8'h00);
        chk("R7 gen off oe", 32'(pin_oe), 0);
        chk("R7 gen off pull", 32'(pin_pu), 0);
        rd(1, 8'h10, 8'h00, "R7 gen off state reads 0");
        wr(8'h40, 8'h09);
        // R11 unmapped and read-only
        rd(1, 8'h63, 8'h00, "R11 unmapped 0x63");
        rd(1, 8'h80, 8'h00, "R11 unmapped 0x80");
        wr(8'h00, 8'h55);
        rd(1, 8'h00, 8'h79, "R11 chip id write ignored");
        wr(8'h10, 8'hFF);
        rd(1, 8'h10, 8'h81, "R11 state write ignored");
        wr(8'h80, 8'hFF);
        chk("R11 unmapped write no pin change", 32'(pin_oe), 32'h800005);
        // R9 / R10 software reset and busy
        wr(8'h40, 8'h80);
        chk("R9 busy after reset write", 32'(busy), 1);
        chk("R9 oe cleared", 32'(pin_oe), 0);
        wr(8'h60, 8'hFF);
        rd(1, 8'h00, 8'h00, "R10 read while busy");
        repeat (BOOT + 5) @(negedge clk);
        chk("R9 busy ends", 32'(busy), 0);
        rd(1, 8'h60, 8'h00, "R10 write during busy ignored");
        rd(1, 8'h40, 8'h00, "R9 sysctrl default");
        rd(1, 8'h6C, 8'h00, "R9 latch default");
        repeat (2) @(negedge clk);
        chk("R3 all reads answered", 32'(exp_q.size()), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule